// File: doc/BRIEF.md
# Pattern-Programmable Two-Input Event Counter

This block counts events on a pair of digital signals, A and B, chosen from the neighbourhood of one input cell. On every clock it registers the two chosen signals. It keeps the sample from the clock before as well. The four bits current A, earlier A, current B and earlier B address a 16-entry table of 2-bit action codes. Software loads the whole table as one 32-bit word. The addressed code holds the count, steps it up or down, clears it, or flags an event.

With a fitting table, one cell can serve as a quadrature decoder, an edge counter, an edge-qualified counter or a detector for illegal transitions. The table does not change the logic. Named constants in the package cover common tables. Software gets results through a read strobe. In report mode the strobe returns a snapshot of the count. In alert-only mode it returns zero, and the alert bit signals that the cell saw any activity at all.

Top module: `edge_pattern_counter`

## Requirements
- R1: The table index is {A, earlier A, B, earlier B} with A in bit 3. Entry i sits in pattern bits [2i+1:2i]. Code 00 holds, 01 adds one and 11 subtracts one. A value presented before rising edge k sets the index seen after edge k. The matching action reaches the count at edge k+1.
- R2: Code 10 leaves the count unchanged and sets a sticky event flag. In report mode that flag drives `in_bit_o`.
- R3: When the clear-mode bit of the loaded configuration is 1, code 11 sets the count to zero instead of subtracting.
- R4: The count wraps modulo 2^CNT_W in both directions: one below 0 is all ones, and one above all ones is 0.
- R5: `sw_clear_i` zeroes the count at the next edge and takes priority over any table action on that edge.
- R6: On the first edge after reset, and on any edge where `cfg_we_i` is high, the earlier-sample bits are set equal to the newly sampled inputs. No table action is applied on those edges.
- R7: On an edge with `rd_i` high, `result_o` takes the count as it stood before that edge and the flag is cleared. If a flag-setting action happens on that same edge, the flag stays set.
- R8: While the report bit is 0 (alert-only), a read returns 0. Any non-hold action sets the flag, so `in_bit_o` reports activity.
- R9: Source selects are numbered as follows with SPAN=3. 0 to 6 pick `pins_i[n]`: 3 is the local pin, 0 to 2 lie below it and 4 to 6 above it. 7 picks `out_own_i`, 8 picks `out_adj_i`, and any higher value yields constant 0.
- R10: The package provides a quadrature table of value 00_01_11_00_11_00_00_01_01_00_00_11_00_11_01_00 (entry 15 first). It also provides a strict variant that sets code 10 where both inputs change at once, and a table that counts rising edges of A.
- R11: After reset, `result_o` and `in_bit_o` are 0, the table holds all zeros (hold), clear mode is off and report mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 2*SPAN+1 | Neighbourhood pins, local pin at index SPAN |
| out_own_i | input | 1 | Output drive of this cell |
| out_adj_i | input | 1 | Output drive of the adjacent cell |
| sel_a_i | input | SEL_W | Source select for A |
| sel_b_i | input | SEL_W | Source select for B |
| cfg_we_i | input | 1 | Load table, clear-mode and report-mode bits |
| cfg_pattern_i | input | 32 | Action table, 16 entries of 2 bits |
| cfg_clr_mode_i | input | 1 | Code 11 clears instead of subtracting |
| cfg_report_i | input | 1 | 1: report count, 0: alert only |
| sw_clear_i | input | 1 | Clear the count |
| rd_i | input | 1 | Read strobe: snapshot the count and clear the flag |
| result_o | output | CNT_W | Count snapshot from the last read |
| in_bit_o | output | 1 | Sticky alert / event flag |

## Verification
A wrong sample in the earlier-value registers shows up as one counted step too many or too few. It becomes visible at the next read, two edges after the input change. A mux that picks the wrong source makes the count follow noise that the bench puts on all unused pins, so the error is caught at the first read. A flag that fails to stick, or fails to clear, is visible on `in_bit_o` one edge after the event or read that should have changed it. Because `in_bit_o` is compared on every cycle, the bench catches this at once.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_INC  = 2'b01,
    ACT_EVT  = 2'b10,
    ACT_DEC  = 2'b11
  } act_e;

  localparam int NCASE = 16;
  localparam int PAT_W = 2 * NCASE;

  // entry 15 in the top pair, entry 0 in the bottom pair
  localparam logic [PAT_W-1:0] PRESET_QUAD =
    32'b00_01_11_00_11_00_00_01_01_00_00_11_00_11_01_00;

  // indices where both A and B changed in one sample: 5, 6, 9, 10
  localparam logic [NCASE-1:0] BOTH_CHANGED = 16'b0000_0110_0110_0000;

  // indices 8..11 have A=1 and earlier A=0
  localparam logic [PAT_W-1:0] PRESET_RISE_A = 32'h0055_0000;

  function automatic logic [PAT_W-1:0] mark_events(input logic [PAT_W-1:0] base,
                                                   input logic [NCASE-1:0] sel);
    logic [PAT_W-1:0] r;
    r = base;
    for (int i = 0; i < NCASE; i++)
      if (sel[i]) r[2*i +: 2] = ACT_EVT;
    return r;
  endfunction

  localparam logic [PAT_W-1:0] PRESET_QUAD_STRICT = mark_events(PRESET_QUAD, BOTH_CHANGED);

endpackage

// File: rtl/epc_src_mux.sv
module epc_src_mux #(
  parameter int SPAN  = 3,
  parameter int SEL_W = 4
) (
  input  logic [2*SPAN:0]  pins_i,
  input  logic             out_own_i,
  input  logic             out_adj_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             src_o
);
  localparam int NPIN = 2 * SPAN + 1;
  localparam int NSRC = NPIN + 2;

  logic [NSRC-1:0] srcs;
  assign srcs = {out_adj_i, out_own_i, pins_i};

  always_comb begin
    src_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(sel_i) == i) src_o = srcs[i];
  end
endmodule

// File: rtl/epc_sampler.sv
module epc_sampler #(
  parameter int SPAN  = 3,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*SPAN:0]  pins_i,
  input  logic             out_own_i,
  input  logic             out_adj_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  input  logic             load_i,
  output logic [3:0]       idx_o,
  output logic             live_o
);
  logic [1:0] src;
  logic [1:0] cur_q, prv_q;
  logic       live_q;
  logic       align;

  for (genvar g = 0; g < 2; g++) begin : g_src
    epc_src_mux #(.SPAN(SPAN), .SEL_W(SEL_W)) u_mux (
      .pins_i    (pins_i),
      .out_own_i (out_own_i),
      .out_adj_i (out_adj_i),
      .sel_i     (g == 0 ? sel_a_i : sel_b_i),
      .src_o     (src[g])
    );
  end

  assign align = !live_q || load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prv_q  <= '0;
      live_q <= 1'b0;
    end else begin
      cur_q  <= src;
      live_q <= 1'b1;
      if (align) prv_q <= src;
      else       prv_q <= cur_q;
    end
  end

  assign idx_o  = {cur_q[0], prv_q[0], cur_q[1], prv_q[1]};
  assign live_o = live_q;

  // R6
  aligned_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    align |=> (cur_q == prv_q));
endmodule

// File: rtl/epc_action_lut.sv
module epc_action_lut
  import epc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic             clr_mode_i,
  input  logic             report_i,
  input  logic [3:0]       idx_i,
  output act_e             code_o,
  output logic             clr_mode_o,
  output logic             report_o
);
  logic [PAT_W-1:0] pat_q;
  logic             clr_mode_q;
  logic             report_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q      <= '0;
      clr_mode_q <= 1'b0;
      report_q   <= 1'b1;
    end else if (load_i) begin
      pat_q      <= pat_i;
      clr_mode_q <= clr_mode_i;
      report_q   <= report_i;
    end
  end

  assign code_o     = act_e'(pat_q[{idx_i, 1'b0} +: 2]);
  assign clr_mode_o = clr_mode_q;
  assign report_o   = report_q;
endmodule

// File: rtl/epc_accum.sv
module epc_accum
  import epc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  act_e             code_i,
  input  logic             clr_mode_i,
  input  logic             report_i,
  input  logic             sw_clr_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] result_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;
  logic             flag_q;
  logic             do_inc, do_dec, do_clr, do_evt, set_flag;

  always_comb begin
    do_inc   = en_i && (code_i == ACT_INC);
    do_dec   = en_i && (code_i == ACT_DEC) && !clr_mode_i;
    do_clr   = en_i && (code_i == ACT_DEC) && clr_mode_i;
    do_evt   = en_i && (code_i == ACT_EVT);
    set_flag = report_i ? do_evt : (en_i && (code_i != ACT_HOLD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (sw_clr_i || do_clr) cnt_q <= '0;
      else if (do_inc)        cnt_q <= cnt_q + 1'b1;
      else if (do_dec)        cnt_q <= cnt_q - 1'b1;

      if (set_flag)  flag_q <= 1'b1;
      else if (rd_i) flag_q <= 1'b0;

      if (rd_i) res_q <= report_i ? cnt_q : '0;
    end
  end

  assign result_o = res_q;
  assign flag_o   = flag_q;

  // R1
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_inc, do_dec, do_clr, do_evt}));
  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (do_inc && !sw_clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (do_dec && !sw_clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_clr_i |=> (cnt_q == '0));
  // R2
  event_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    (do_evt && !sw_clr_i) |=> $stable(cnt_q));
  // R2
  event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_i) |=> flag_q);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !set_flag) |=> !flag_q);
  // R8
  alert_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !report_i) |=> (res_q == '0));
endmodule

// File: rtl/edge_pattern_counter.sv
module edge_pattern_counter
  import epc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SPAN  = 3,
  localparam int NSRC  = 2 * SPAN + 3,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*SPAN:0]  pins_i,
  input  logic             out_own_i,
  input  logic             out_adj_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  input  logic             cfg_we_i,
  input  logic [PAT_W-1:0] cfg_pattern_i,
  input  logic             cfg_clr_mode_i,
  input  logic             cfg_report_i,
  input  logic             sw_clear_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] result_o,
  output logic             in_bit_o
);
  logic [3:0] idx;
  logic       live;
  act_e       code;
  logic       clr_mode, report;

  epc_sampler #(.SPAN(SPAN), .SEL_W(SEL_W)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (pins_i),
    .out_own_i (out_own_i),
    .out_adj_i (out_adj_i),
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .load_i    (cfg_we_i),
    .idx_o     (idx),
    .live_o    (live)
  );

  epc_action_lut u_lut (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cfg_we_i),
    .pat_i      (cfg_pattern_i),
    .clr_mode_i (cfg_clr_mode_i),
    .report_i   (cfg_report_i),
    .idx_i      (idx),
    .code_o     (code),
    .clr_mode_o (clr_mode),
    .report_o   (report)
  );

  epc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .en_i       (live && !cfg_we_i),
    .code_i     (code),
    .clr_mode_i (clr_mode),
    .report_i   (report),
    .sw_clr_i   (sw_clear_i),
    .rd_i       (rd_i),
    .result_o   (result_o),
    .flag_o     (in_bit_o)
  );
endmodule

// File: tb/sim_edge_pattern_counter.sv
module sim_edge_pattern_counter;
  import epc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  pins = '0;
  logic        out_own = 1'b0, out_adj = 1'b0;
  logic [3:0]  sel_a = 4'd3, sel_b = 4'd4;
  logic        cfg_we = 1'b0, cfg_cm = 1'b0, cfg_rp = 1'b1;
  logic [31:0] cfg_pat = '0;
  logic        sw_clr = 1'b0, rd = 1'b0;
  logic [31:0] result;
  logic        in_bit;

  always #10 clk = ~clk;

  edge_pattern_counter u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .out_own_i(out_own), .out_adj_i(out_adj),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .cfg_we_i(cfg_we), .cfg_pattern_i(cfg_pat),
    .cfg_clr_mode_i(cfg_cm), .cfg_report_i(cfg_rp), .sw_clear_i(sw_clr), .rd_i(rd),
    .result_o(result), .in_bit_o(in_bit)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    bit          has_res;
    logic [31:0] res;
    bit          flg;
    string       tag;
  } exp_t;
  exp_t q[$];

  // model of the requirements
  bit [31:0] m_pat, m_cnt;
  bit        m_cm, m_rp, m_live, m_flag, m_pa, m_pb, m_pv;
  bit [1:0]  m_pend;

  task automatic place(input bit v, input logic [3:0] s);
    if (s < 7)       pins[s] = v;
    else if (s == 7) out_own = v;
    else if (s == 8) out_adj = v;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic tick(input bit a, input bit b, input string tag,
                      input bit r = 0, input bit c = 0, input bit we = 0,
                      input bit [31:0] pat = 0, input bit cm = 0, input bit rp = 1);
    exp_t e;
    bit [3:0] idx;
    bit pa, pb, setf;
    pins = 7'($urandom); out_own = 1'($urandom); out_adj = 1'($urandom);
    place(a, sel_a); place(b, sel_b);
    rd = r; sw_clr = c; cfg_we = we; cfg_pat = pat; cfg_cm = cm; cfg_rp = rp;
    e.has_res = r; e.res = m_rp ? m_cnt : 32'd0; e.tag = tag;
    setf = 0;
    if (m_pv && !we) begin
      setf = m_rp ? (m_pend == 2'b10) : (m_pend != 2'b00);
      if (!c) begin
        if (m_pend == 2'b01) m_cnt = m_cnt + 1;
        else if (m_pend == 2'b11) m_cnt = m_cm ? 32'd0 : m_cnt - 1;
      end
    end
    if (c) m_cnt = 0;
    if (setf) m_flag = 1; else if (r) m_flag = 0;
    e.flg = m_flag;
    if (we) begin m_pat = pat; m_cm = cm; m_rp = rp; end
    pa = (!m_live || we) ? a : m_pa;
    pb = (!m_live || we) ? b : m_pb;
    idx = {a, pa, b, pb};
    m_pend = m_pat[2*idx +: 2];
    m_pv = 1; m_live = 1; m_pa = a; m_pb = b;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    rd = 0; sw_clr = 0; cfg_we = 0;
  endtask

  // monitor: pop expected items and compare
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (in_bit !== e.flg) begin
          n_bad++;
          $display("FAIL %s in_bit actual=%0b expected=%0b", e.tag, in_bit, e.flg);
        end
        if (e.has_res) begin
          n_chk++;
          if (result !== e.res) begin
            n_bad++;
            $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.res);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic quad_fwd(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(1,0,tag); tick(1,1,tag); tick(0,1,tag); tick(0,0,tag);
    end
  endtask

  initial begin
    m_cnt = 0; m_flag = 0; m_pat = 0; m_cm = 0; m_rp = 1; m_live = 0; m_pv = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_chk++;
    if (result !== 32'd0 || in_bit !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset actual=%h/%0b expected=0/0", result, in_bit);
    end
    rst = 0;
    tick(1,0,"R11"); tick(0,1,"R11"); tick(0,0,"R11", 1);

    // R10 quadrature preset, R1 both directions
    tick(0,0,"R10", 0,0,1, PRESET_QUAD);
    quad_fwd(2, "R10");
    tick(0,0,"R1"); tick(0,0,"R1", 1);
    tick(0,1,"R1"); tick(1,1,"R1"); tick(1,0,"R1"); tick(0,0,"R1"); tick(0,0,"R1", 1);

    // R4 wrap below zero and back
    tick(0,0,"R5", 0,1);
    tick(0,1,"R4"); tick(0,1,"R4"); tick(0,1,"R4", 1);
    tick(0,0,"R4"); tick(0,0,"R4"); tick(0,0,"R4", 1);

    // R2 illegal jump with strict table, sticky flag, R7 set wins over read
    tick(0,0,"R2", 0,0,1, PRESET_QUAD_STRICT);
    tick(1,1,"R2"); tick(1,1,"R7", 1); tick(1,1,"R2"); tick(1,1,"R2"); tick(1,1,"R7", 1);
    tick(1,1,"R7");

    // R1 rising edges of A; R6 load while A rises counts nothing
    tick(0,0,"R6", 0,0,1, PRESET_RISE_A);
    tick(1,0,"R1"); tick(0,0,"R1"); tick(1,0,"R1"); tick(1,0,"R1"); tick(0,0,"R1");
    tick(1,0,"R6", 0,0,1, PRESET_RISE_A);
    tick(1,0,"R6"); tick(1,0,"R6", 1);

    // R5 clear beats a pending increment
    tick(0,0,"R5"); tick(1,0,"R5"); tick(1,0,"R5", 0,1); tick(1,0,"R5", 1);

    // R3 clear mode on code 11, then plain decrement
    tick(0,0,"R3"); tick(1,0,"R3"); tick(0,0,"R3"); tick(1,0,"R3"); tick(0,0,"R3");
    tick(0,0,"R3", 0,0,1, 32'h00FF_0000, 1);
    tick(1,0,"R3"); tick(1,0,"R3"); tick(1,0,"R3", 1);
    tick(0,0,"R3", 0,0,1, 32'h00FF_0000, 0);
    tick(1,0,"R3"); tick(1,0,"R3"); tick(1,0,"R3", 1);

    // R8 alert-only mode
    tick(0,0,"R8", 0,0,1, PRESET_RISE_A, 0, 0);
    tick(0,0,"R8"); tick(1,0,"R8"); tick(0,0,"R8"); tick(0,0,"R8", 1); tick(0,0,"R8");

    // R9 other sources: adjacent out and lowest pin, own out, unmapped select
    sel_a = 4'd8; sel_b = 4'd0;
    tick(0,0,"R9", 0,1,1, PRESET_QUAD);
    quad_fwd(3, "R9");
    tick(0,0,"R9"); tick(0,0,"R9", 1);
    sel_a = 4'd7; sel_b = 4'd6;
    tick(0,0,"R9", 0,1,1, PRESET_RISE_A);
    tick(1,0,"R9"); tick(0,0,"R9"); tick(1,0,"R9"); tick(1,0,"R9", 1);
    sel_a = 4'd12; sel_b = 4'd5;
    tick(0,0,"R9", 0,1,1, PRESET_RISE_A);
    tick(0,1,"R9"); tick(0,0,"R9"); tick(0,1,"R9"); tick(0,1,"R9", 1);

    tick(0,0,"R9"); tick(0,0,"R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule